// File: doc/BRIEF.md
# Triggered External-Clock Up-Counter

This block is an up-counter run by a small slave controller. The counter stays frozen until a chosen edge on the channel-1 input starts it. From then on it does not advance on the system clock. It advances on edges of a separate external clock pin. Each asynchronous pin passes through a two-flop synchroniser and then a registered edge detector. On the external pin, a sample-count glitch filter and a power-of-two prescaler can be added to that path. A count therefore follows its pin edge by a fixed number of system clocks.

The mode fields, the source fields, the polarity bits, the prescaler code and the filter code are inputs that hold steady while the block runs. The run controller has two states. In `ST_HALT` the counter is stopped and `cen` is low. In `ST_RUN` the counter may advance and `cen` is high. There is one transition, named *trigger start*, from `ST_HALT` to `ST_RUN`. It is taken on a selected trigger edge when the slave mode is trigger mode. `ST_RUN` stays in `ST_RUN` (*hold*), and only reset leaves it.

Each edge path has its own filter controller with two states. `FL_STEADY` means the accepted level matches the input. `FL_PENDING` means a differing input level is being timed. The filter has three transitions:
- *start timing*: from `FL_STEADY` to `FL_PENDING` when the input differs and the code is 2 or more.
- *abandon*: from `FL_PENDING` to `FL_STEADY` when the input returns to the accepted level.
- *accept*: from `FL_PENDING` to `FL_STEADY` when the input has differed for the full count.

Top module: `tsc_slave_timer`

## Requirements
- R1: After reset, `cnt` is 0, `cen` is 0 and `trig_flag` is 0.
- R2: A trigger edge starts the run only when `slave_mode` is 3'b110 and `trig_src` is 5'b00101. The edge sets `cen` on the third rising system-clock edge after the `ch1_pin` change. For any other mode or source, `ch1_pin` has no effect on `cen` or `trig_flag`. Once set, `cen` stays 1 until reset.
- R3: The channel-1 edge is selected by {`ch1_pol`,`ch1_npol`]: 2'b00 and 2'b01 select rising, 2'b10 selects falling, and 2'b11 selects both edges.
- R4: Every qualifying trigger edge sets `trig_flag`, including edges that arrive while the counter is already running. The flag stays set until `flag_clr` is sampled high. If a trigger edge and `flag_clr` occur in the same cycle, the trigger edge wins.
- R5: A trigger edge that arrives while the counter is running leaves `cnt` unchanged.
- R6: While `cen` is 1 and `ext_clk_en` is 1, `cnt` increases by exactly one for each edge that passes the prescaler. While either of them is 0, `cnt` holds.
- R7: When `ext_pol` is 0, rising edges of `ext_pin` are active. When `ext_pol` is 1, falling edges are active.
- R8: The `ext_psc` codes 2'b00, 01, 10 and 11 pass one active edge in every 1, 2, 4 and 8 respectively. The edge that passes is the last one of each group. The prescaler starts from zero at reset, and it advances only while the counter is enabled and `ext_clk_en` is 1.
- R9: When `ext_flt` is 0, `cnt` changes on the third rising system-clock edge after the `ext_pin` change.
- R10: When `ext_flt` is N (1 to 15), a change of the synchronised `ext_pin` level is accepted only after the new level is sampled on N consecutive clocks. Shorter pulses are ignored, and the latency becomes 3+N clocks.
- R11: `cnt` is CNT_W bits wide (16 by default) and wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external clock pin |
| ch1_pin | input | 1 | Asynchronous channel-1 trigger pin |
| slave_mode | input | 3 | Slave mode select; 3'b110 is trigger mode |
| trig_src | input | 5 | Trigger source select; 5'b00101 is channel 1 |
| ext_clk_en | input | 1 | Enables counting on external pin edges |
| ext_pol | input | 1 | External pin active edge: 0 rising, 1 falling |
| ext_psc | input | 2 | External prescaler code |
| ext_flt | input | 4 | External filter sample count, 0 is off |
| ch1_pol | input | 1 | Channel-1 polarity bit |
| ch1_npol | input | 1 | Channel-1 complementary polarity bit |
| flag_clr | input | 1 | Clears the trigger flag |
| cen | output | 1 | Counter enable state |
| trig_flag | output | 1 | Sticky trigger flag |
| cnt | output | CNT_W | Counter value |

## Verification
The assertions take three things for granted about the inputs:
- The filter code does not change while the block is out of reset. The filter's hold-time property relies on this.
- An active edge cannot occur on two clocks in a row, because each pin passes through the synchroniser and the edge detector.
- The configuration inputs are steady between reset pulses.

The stimulus meets these assumptions in the following ways:
- It changes configuration only while reset is asserted, or between pulses at a falling clock edge.
- It moves both pins at offsets that vary inside the clock period and never land on a rising edge.
- It holds every pin level for at least two clocks, except for the deliberate short pulses aimed at the filter.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam logic [2:0] SMS_TRIGGER = 3'b110;
    localparam logic [4:0] TS_CH1      = 5'b00101;

    typedef enum logic {
        ST_HALT,
        ST_RUN
    } run_st_t;

    typedef enum logic {
        FL_STEADY,
        FL_PENDING
    } flt_st_t;

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic meta_q;
            logic sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                end else begin
                    meta_q <= d[i];
                    sync_q <= meta_q;
                end
            end
            assign q[i] = sync_q;
        end
    endgenerate

endmodule

// File: rtl/tsc_edge_det.sv
module tsc_edge_det
    import tsc_pkg::*;
#(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic [FLT_W-1:0] flt_code,
    output logic             rise,
    output logic             fall
);

    flt_st_t          st_q, st_d;
    logic [FLT_W-1:0] run_q, run_d;
    logic             acc_q, acc_d;
    logic             level;
    logic             level_d;

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        acc_d = acc_q;
        if (flt_code == '0) begin
            st_d  = FL_STEADY;
            run_d = '0;
            acc_d = lvl;
        end else begin
            unique case (st_q)
                FL_STEADY: begin
                    if (lvl != acc_q) begin
                        if (flt_code == FLT_W'(1)) begin
                            acc_d = lvl;
                        end else begin
                            st_d  = FL_PENDING;
                            run_d = FLT_W'(1);
                        end
                    end
                end
                FL_PENDING: begin
                    if (lvl == acc_q) begin
                        st_d  = FL_STEADY;
                        run_d = '0;
                    end else if (run_q == flt_code - FLT_W'(1)) begin
                        st_d  = FL_STEADY;
                        run_d = '0;
                        acc_d = lvl;
                    end else begin
                        run_d = run_q + FLT_W'(1);
                    end
                end
                default: st_d = FL_STEADY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= FL_STEADY;
            run_q   <= '0;
            acc_q   <= 1'b0;
            level_d <= 1'b0;
        end else begin
            st_q    <= st_d;
            run_q   <= run_d;
            acc_q   <= acc_d;
            level_d <= level;
        end
    end

    always_comb begin
        level = (flt_code == '0) ? lvl : acc_q;
        rise  = level & ~level_d;
        fall  = ~level & level_d;
    end

    a_r9_rise_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    a_r10_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_code >= FLT_W'(2) && acc_q != $past(acc_q)) |-> ($past(lvl, 2) == acc_q));

endmodule

// File: rtl/tsc_ext_psc.sv
module tsc_ext_psc #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              adv,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    localparam int PW = (1 << CODE_W) - 1;

    logic [PW-1:0] ctr_q;
    logic [PW-1:0] mask;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            mask[i] = (i < int'(code));
        end
        tick = act & adv & ((ctr_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else if (act && adv) begin
            ctr_q <= ctr_q + PW'(1);
        end
    end

    a_r8_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/tsc_slave_timer.sv
module tsc_slave_timer
    import tsc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int FLT_W = 4,
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             ch1_pin,
    input  logic [2:0]       slave_mode,
    input  logic [4:0]       trig_src,
    input  logic             ext_clk_en,
    input  logic             ext_pol,
    input  logic [PSC_W-1:0] ext_psc,
    input  logic [FLT_W-1:0] ext_flt,
    input  logic             ch1_pol,
    input  logic             ch1_npol,
    input  logic             flag_clr,
    output logic             cen,
    output logic             trig_flag,
    output logic [CNT_W-1:0] cnt
);

    logic [1:0] sync_q;
    logic       ext_rise, ext_fall;
    logic       ch1_rise, ch1_fall;
    logic       trig_edge, trig_hit;
    logic       ext_act, count_en, psc_tick;
    run_st_t    st_q, st_d;

    tsc_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ch1_pin, ext_pin}),
        .q     (sync_q)
    );

    tsc_edge_det #(.FLT_W(FLT_W)) u_ext_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (sync_q[0]),
        .flt_code (ext_flt),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    tsc_edge_det #(.FLT_W(FLT_W)) u_ch1_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (sync_q[1]),
        .flt_code ('0),
        .rise     (ch1_rise),
        .fall     (ch1_fall)
    );

    always_comb begin
        unique case ({ch1_pol, ch1_npol})
            2'b11:   trig_edge = ch1_rise | ch1_fall;
            2'b10:   trig_edge = ch1_fall;
            default: trig_edge = ch1_rise;
        endcase
        trig_hit = trig_edge && (slave_mode == SMS_TRIGGER) && (trig_src == TS_CH1);
        ext_act  = ext_pol ? ext_fall : ext_rise;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (trig_hit) st_d = ST_RUN;
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    always_comb begin
        cen      = (st_q == ST_RUN);
        count_en = cen & ext_clk_en;
    end

    tsc_ext_psc #(.CODE_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (ext_act),
        .adv   (count_en),
        .code  (ext_psc),
        .tick  (psc_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            trig_flag <= 1'b0;
        end else begin
            if (psc_tick) cnt <= cnt + CNT_W'(1);
            if (trig_hit)      trig_flag <= 1'b1;
            else if (flag_clr) trig_flag <= 1'b0;
        end
    end

    a_r2_cen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cen |=> cen);

    a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag && !flag_clr) |=> trig_flag);

    a_r6_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen || !ext_clk_en) |=> $stable(cnt));

    a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: tb/tsc_slave_timer_test.sv
`timescale 1ns/1ps
module tsc_slave_timer_test;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pin = 1'b0, ch1_pin = 1'b0;
    logic [2:0] slave_mode = 3'b110;
    logic [4:0] trig_src = 5'b00101;
    logic ext_clk_en = 1'b1, ext_pol = 1'b0;
    logic [1:0] ext_psc = 2'b00;
    logic [3:0] ext_flt = 4'd0;
    logic ch1_pol = 1'b0, ch1_npol = 1'b0, flag_clr = 1'b0;
    logic cen, trig_flag;
    logic [W-1:0] cnt;

    int n_chk = 0, n_err = 0, ofs = 0, base;
    bit done = 0;

    bit h_e[0:19];
    bit h_c[0:19];
    int m_cnt, m_psc;
    bit m_cen, m_flag, m_flt, m_flt_prev;

    always #10 clk = ~clk;

    tsc_slave_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ch1_pin(ch1_pin),
        .slave_mode(slave_mode), .trig_src(trig_src), .ext_clk_en(ext_clk_en),
        .ext_pol(ext_pol), .ext_psc(ext_psc), .ext_flt(ext_flt),
        .ch1_pol(ch1_pol), .ch1_npol(ch1_npol), .flag_clr(flag_clr),
        .cen(cen), .trig_flag(trig_flag), .cnt(cnt)
    );

    always @(posedge clk) begin
        bit nl, ol, cn, co, te, act, ok;
        int div;
        if (!rst_n) begin
            for (int i = 0; i < 20; i++) begin h_e[i] = 0; h_c[i] = 0; end
            m_cnt = 0; m_psc = 0; m_cen = 0; m_flag = 0; m_flt = 0; m_flt_prev = 0;
        end else begin
            for (int i = 19; i > 0; i--) begin h_e[i] = h_e[i-1]; h_c[i] = h_c[i-1]; end
            h_e[0] = ext_pin; h_c[0] = ch1_pin;
            if (ext_flt == 0) begin
                nl = h_e[2]; ol = h_e[3];
            end else begin
                nl = m_flt; ol = m_flt_prev; m_flt_prev = m_flt;
                ok = 1;
                for (int i = 2; i <= int'(ext_flt) + 1; i++) if (h_e[i] == m_flt) ok = 0;
                if (ok) m_flt = h_e[2];
            end
            act = ext_pol ? (ol && !nl) : (nl && !ol);
            cn = h_c[2]; co = h_c[3];
            if (ch1_pol && ch1_npol) te = (cn != co);
            else if (ch1_pol)        te = co && !cn;
            else                     te = cn && !co;
            te = te && slave_mode == 3'b110 && trig_src == 5'b00101;
            div = 1 << ext_psc;
            if (m_cen && ext_clk_en && act) begin
                if ((m_psc % div) == div - 1) m_cnt = (m_cnt + 1) % (1 << W);
                m_psc = (m_psc + 1) % 8;
            end
            if (te) begin m_cen = 1; m_flag = 1; end
            else if (flag_clr) m_flag = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(cnt) == m_cnt, "R6 model counter", int'(cnt), m_cnt);
            chk(cen == m_cen, "R2 model enable", int'(cen), int'(m_cen));
            chk(trig_flag == m_flag, "R4 model flag", int'(trig_flag), int'(m_flag));
        end
    end

    function automatic int off();
        ofs = (ofs + 7) % 15;
        return 3 + ofs;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ext(input int hi, input int lo);
        @(posedge clk); #(off()); ext_pin = 1'b1;
        repeat (hi) @(posedge clk); #(off()); ext_pin = 1'b0;
        repeat (lo) @(posedge clk);
    endtask

    task automatic pulse_ch1(input int hi, input int lo);
        @(posedge clk); #(off()); ch1_pin = ~ch1_pin;
        repeat (hi) @(posedge clk); #(off()); ch1_pin = ~ch1_pin;
        repeat (lo) @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        ext_pin = 1'b0; ch1_pin = 1'b0;
        cyc(3); rst_n = 1'b1; cyc(1);
    endtask

    task automatic start_run();
        pulse_ch1(3, 4);
        @(negedge clk);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk(cnt == 0, "R1 reset cnt", int'(cnt), 0);
        chk(cen == 0, "R1 reset cen", int'(cen), 0);
        chk(trig_flag == 0, "R1 reset flag", int'(trig_flag), 0);

        slave_mode = 3'b000;
        pulse_ch1(3, 4); pulse_ext(2, 2); @(negedge clk);
        chk(cen == 0, "R2 wrong mode ignored", int'(cen), 0);
        chk(trig_flag == 0, "R2 wrong mode no flag", int'(trig_flag), 0);
        slave_mode = 3'b110; trig_src = 5'b00000;
        pulse_ch1(3, 4); @(negedge clk);
        chk(cen == 0, "R2 wrong source ignored", int'(cen), 0);
        trig_src = 5'b00101;
        chk(cnt == 0, "R6 no count while halted", int'(cnt), 0);

        @(posedge clk); #5 ch1_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(cen == 0, "R2 enable after 1 edge", int'(cen), 0);
        @(negedge clk);
        chk(cen == 0, "R2 enable after 2 edges", int'(cen), 0);
        @(negedge clk);
        chk(cen == 1, "R2 enable after 3 edges", int'(cen), 1);
        chk(trig_flag == 1, "R4 flag set by trigger", int'(trig_flag), 1);
        #3 ch1_pin = 1'b0; cyc(4);

        base = cnt;
        @(posedge clk); #5 ext_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(cnt == base, "R9 latency edge 1", int'(cnt), base);
        @(negedge clk);
        chk(cnt == base, "R9 latency edge 2", int'(cnt), base);
        @(negedge clk);
        chk(int'(cnt) == base + 1, "R9 latency edge 3", int'(cnt), base + 1);
        #3 ext_pin = 1'b0; cyc(3);

        for (int i = 0; i < 5; i++) pulse_ext(2, 3);
        cyc(4);
        chk(cnt == 6, "R6 five more edges", int'(cnt), 6);

        @(negedge clk) flag_clr = 1'b1; @(negedge clk) flag_clr = 1'b0;
        chk(trig_flag == 0, "R4 flag cleared", int'(trig_flag), 0);
        base = cnt;
        pulse_ch1(3, 5); @(negedge clk);
        chk(int'(cnt) == base, "R5 retrigger keeps count", int'(cnt), base);
        chk(trig_flag == 1, "R4 retrigger sets flag", int'(trig_flag), 1);
        flag_clr = 1'b1; pulse_ch1(3, 5); @(negedge clk); flag_clr = 1'b0;
        cyc(1);

        ext_clk_en = 1'b0;
        for (int i = 0; i < 3; i++) pulse_ext(2, 3);
        cyc(4);
        chk(cnt == 6, "R6 disabled clock holds", int'(cnt), 6);
        ext_clk_en = 1'b1;

        do_reset(); start_run();
        ext_psc = 2'b10;
        for (int i = 0; i < 8; i++) pulse_ext(3, 3);
        cyc(5);
        chk(cnt == 2, "R8 divide by 4", int'(cnt), 2);
        ext_psc = 2'b11;
        for (int i = 0; i < 16; i++) pulse_ext(2, 2);
        cyc(5);
        chk(cnt == 4, "R8 divide by 8", int'(cnt), 4);
        ext_psc = 2'b01;
        for (int i = 0; i < 6; i++) pulse_ext(2, 2);
        cyc(5);
        chk(cnt == 7, "R8 divide by 2", int'(cnt), 7);
        ext_psc = 2'b00;

        ext_pol = 1'b1; do_reset(); start_run();
        @(posedge clk); #6 ext_pin = 1'b1; cyc(6);
        chk(cnt == 0, "R7 rising ignored when falling active", int'(cnt), 0);
        @(posedge clk); #6 ext_pin = 1'b0; cyc(6);
        chk(cnt == 1, "R7 falling edge counted", int'(cnt), 1);
        ext_pol = 1'b0;

        ext_flt = 4'd3; do_reset(); start_run();
        pulse_ext(2, 8); cyc(2);
        chk(cnt == 0, "R10 short pulse rejected", int'(cnt), 0);
        @(posedge clk); #5 ext_pin = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 5; k++) @(negedge clk);
        chk(cnt == 0, "R10 latency edge 5", int'(cnt), 0);
        @(negedge clk);
        chk(cnt == 1, "R10 latency edge 6", int'(cnt), 1);
        #3 ext_pin = 1'b0; cyc(8);
        ext_flt = 4'd0;

        do_reset(); start_run();
        for (int i = 0; i < 255; i++) pulse_ext(2, 2);
        cyc(4);
        chk(cnt == 255, "R11 reaches all ones", int'(cnt), 255);
        for (int i = 0; i < 3; i++) pulse_ext(2, 2);
        cyc(4);
        chk(cnt == 2, "R11 wrap to zero", int'(cnt), 2);

        ch1_pol = 1'b1; ch1_npol = 1'b0; do_reset();
        @(posedge clk); #7 ch1_pin = 1'b1; cyc(6);
        chk(cen == 0, "R3 rising ignored in falling mode", int'(cen), 0);
        @(posedge clk); #7 ch1_pin = 1'b0; cyc(6);
        chk(cen == 1, "R3 falling edge triggers", int'(cen), 1);
        ch1_npol = 1'b1; do_reset();
        @(posedge clk); #7 ch1_pin = 1'b1; cyc(6);
        chk(cen == 1, "R3 both-edge rising triggers", int'(cen), 1);
        @(negedge clk) flag_clr = 1'b1; @(negedge clk) flag_clr = 1'b0;
        @(posedge clk); #7 ch1_pin = 1'b0; cyc(6);
        chk(trig_flag == 1, "R3 both-edge falling sets flag", int'(trig_flag), 1);

        cyc(2);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule